// File: doc/BRIEF.md
# Multi-Type Clock-Domain Crossing Bridge

This block carries control and status information from one clock domain into another, unrelated one. It holds four independent channels, each picking the crossing method that suits its kind of signal. A slow one-bit level goes through a plain flop chain. A single-cycle event goes through a request/acknowledge loop, so the event appears exactly once in the destination domain. A multi-bit value that keeps changing goes through a three-state handshake machine, which samples it again and again. A multi-bit value that software only reads long after it settled goes through one destination register.

Every channel runs from the source clock to the destination clock. Each domain has its own synchronous active-high reset. The block is placed wherever status counters, enables or clear strobes must pass between two otherwise independent clock regions.

Top module: `cdc_bridge`

## Requirements
- R1: `lvl_out` takes the value of `lvl_in` after passing through `LVL_STAGES` destination-clock flops; a level held for several destination cycles always arrives.
- R2: Every source pulse on `pls_in` that is accepted produces exactly one `pls_out` pulse, one destination cycle wide, a few cycles later.
- R3: An accepted pulse sets a held source request. The request clears only when a rising edge of the destination request is seen on the top two stages of a three-flop feedback chain in the source domain. A later isolated pulse, issued after that loop has settled, is accepted again.
- R4: A source pulse that arrives while a transfer is pending is merged into that transfer. This covers the time the request is high and the time the fed-back request is still high. Such a pulse yields no second `pls_out` pulse.
- R5: After `bus_in` has been stable for one full handshake loop, `bus_out` equals it. `bus_out` changes only when the destination valid shows a rising edge on the top two of its three synchronizer flops.
- R6: The bus machine cycles forever through its three states. In the update state (code 0) it latches `bus_in` and raises valid, then enters the latched state (code 1). In the latched state it waits for fed-back valid and then drops valid. In the clear state (code 2) valid stays low, and the machine waits for the feedback to fall before it returns to the update state.
- R7: `qs_out` equals the value `qs_in` had one destination clock earlier, with no handshake.
- R8: While `src_rst` and `dst_rst` are high, every flop of its domain is cleared, so `lvl_out`, `pls_out`, `bus_out` and `qs_out` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-domain clock |
| src_rst | input | 1 | Source-domain synchronous active-high reset |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst | input | 1 | Destination-domain synchronous active-high reset |
| lvl_in | input | 1 | Slow one-bit level, source domain |
| lvl_out | output | 1 | Synchronized level, destination domain |
| pls_in | input | 1 | One-cycle event, source domain |
| pls_out | output | 1 | One-cycle event, destination domain |
| bus_in | input | BUS_W | Continuously changing value, source domain |
| bus_out | output | BUS_W | Refreshed copy of `bus_in`, destination domain |
| qs_in | input | QS_W | Quasi-static value, source domain |
| qs_out | output | QS_W | Registered copy of `qs_in`, destination domain |

## Verification
The bench builds the block with `LVL_STAGES` = 2, `BUS_W` = 16 and `QS_W` = 12. It runs a 10 ns source clock against a 14 ns destination clock, so the phase between the domains drifts and every handshake lands on different edge alignments. The narrow bus widths still reach all-ones, alternating and single-bit patterns in `bus_in` and `qs_in`. Pulse bursts spaced closer than one handshake loop exercise the merge rule, and widely spaced pulses exercise re-acceptance after the loop settles.

// File: rtl/cdc_bridge_pkg.sv
package cdc_bridge_pkg;
  typedef enum logic [1:0] {
    BUS_UPD = 2'd0,
    BUS_LAT = 2'd1,
    BUS_CLR = 2'd2
  } bus_st_e;

  localparam int HS_STAGES = 3;
endpackage

// File: rtl/cdc_level.sv
module cdc_level #(
  parameter int STAGES = 2
) (
  input  logic dst_clk,
  input  logic dst_rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge dst_clk) begin
    if (dst_rst) sh <= '0;
    else         sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/cdc_pulse.sv
module cdc_pulse
  import cdc_bridge_pkg::*;
(
  input  logic src_clk,
  input  logic src_rst,
  input  logic dst_clk,
  input  logic dst_rst,
  input  logic pin,
  output logic pout
);
  logic                 req;
  logic [HS_STAGES-1:0] fb;
  logic [HS_STAGES-1:0] dreq;
  logic                 ack_edge;

  // ack seen as a rising edge on the two oldest feedback stages
  assign ack_edge = fb[HS_STAGES-2] & ~fb[HS_STAGES-1];

  always_ff @(posedge src_clk) begin
    if (src_rst) begin
      req <= 1'b0;
      fb  <= '0;
    end else begin
      fb <= {fb[HS_STAGES-2:0], dreq[HS_STAGES-1]};
      if (ack_edge)
        req <= 1'b0;
      else if (pin && !req && !fb[HS_STAGES-1])
        req <= 1'b1;
    end
  end

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      dreq <= '0;
      pout <= 1'b0;
    end else begin
      dreq <= {dreq[HS_STAGES-2:0], req};
      pout <= dreq[HS_STAGES-2] & ~dreq[HS_STAGES-1];
    end
  end
endmodule

// File: rtl/cdc_bus.sv
module cdc_bus
  import cdc_bridge_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         src_clk,
  input  logic         src_rst,
  input  logic         dst_clk,
  input  logic         dst_rst,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out
);
  bus_st_e              st;
  logic                 vld;
  logic [W-1:0]         lat;
  logic [HS_STAGES-1:0] fb;
  logic [HS_STAGES-1:0] v_dst;

  always_ff @(posedge src_clk) begin
    if (src_rst) begin
      st  <= BUS_UPD;
      vld <= 1'b0;
      lat <= '0;
      fb  <= '0;
    end else begin
      fb <= {fb[HS_STAGES-2:0], v_dst[HS_STAGES-1]};
      case (st)
        BUS_UPD: begin
          lat <= bus_in;
          vld <= 1'b1;
          st  <= BUS_LAT;
        end
        BUS_LAT: begin
          if (fb[HS_STAGES-1]) begin
            vld <= 1'b0;
            st  <= BUS_CLR;
          end
        end
        BUS_CLR: begin
          if (!fb[HS_STAGES-1]) st <= BUS_UPD;
        end
        default: begin
          vld <= 1'b0;
          st  <= BUS_UPD;
        end
      endcase
    end
  end

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      v_dst   <= '0;
      bus_out <= '0;
    end else begin
      v_dst <= {v_dst[HS_STAGES-2:0], vld};
      if (v_dst[HS_STAGES-2] && !v_dst[HS_STAGES-1]) bus_out <= lat;
    end
  end
endmodule

// File: rtl/cdc_quasi.sv
module cdc_quasi #(
  parameter int W = 32
) (
  input  logic         dst_clk,
  input  logic         dst_rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge dst_clk) begin
    if (dst_rst) q <= '0;
    else         q <= d;
  end
endmodule

// File: rtl/cdc_bridge.sv
module cdc_bridge #(
  parameter int LVL_STAGES = 2,
  parameter int BUS_W      = 32,
  parameter int QS_W       = 32
) (
  input  logic             src_clk,
  input  logic             src_rst,
  input  logic             dst_clk,
  input  logic             dst_rst,
  input  logic             lvl_in,
  output logic             lvl_out,
  input  logic             pls_in,
  output logic             pls_out,
  input  logic [BUS_W-1:0] bus_in,
  output logic [BUS_W-1:0] bus_out,
  input  logic [QS_W-1:0]  qs_in,
  output logic [QS_W-1:0]  qs_out
);
  cdc_level #(.STAGES(LVL_STAGES)) u_level (
    .dst_clk(dst_clk), .dst_rst(dst_rst), .d(lvl_in), .q(lvl_out)
  );

  cdc_pulse u_pulse (
    .src_clk(src_clk), .src_rst(src_rst), .dst_clk(dst_clk), .dst_rst(dst_rst),
    .pin(pls_in), .pout(pls_out)
  );

  cdc_bus #(.W(BUS_W)) u_bus (
    .src_clk(src_clk), .src_rst(src_rst), .dst_clk(dst_clk), .dst_rst(dst_rst),
    .bus_in(bus_in), .bus_out(bus_out)
  );

  cdc_quasi #(.W(QS_W)) u_quasi (
    .dst_clk(dst_clk), .dst_rst(dst_rst), .d(qs_in), .q(qs_out)
  );
endmodule

// File: rtl/cdc_bridge_chk.sv
module cdc_bridge_chk #(
  parameter int BUS_W = 32,
  parameter int QS_W  = 32
) (
  input logic             src_clk,
  input logic             src_rst,
  input logic             dst_clk,
  input logic             dst_rst,
  input logic             pls_out,
  input logic [BUS_W-1:0] bus_out,
  input logic [QS_W-1:0]  qs_in,
  input logic [QS_W-1:0]  qs_out,
  input logic             p_req,
  input logic [2:0]       p_fb,
  input logic [1:0]       b_st,
  input logic             b_vld,
  input logic [2:0]       b_v
);
  // R2: output event is one destination cycle wide
  assert_pulse_width_R2: assert property (@(posedge dst_clk) disable iff (dst_rst)
    pls_out |=> !pls_out);

  // R3: held request survives until the feedback edge
  assert_req_hold_R3: assert property (@(posedge src_clk) disable iff (src_rst)
    (p_req && !(p_fb[1] && !p_fb[2])) |=> p_req);

  // R4: no new request while feedback still high
  assert_no_reissue_R4: assert property (@(posedge src_clk) disable iff (src_rst)
    (!p_req && p_fb[2]) |=> !p_req);

  // R5: destination bus moves only after a valid rising edge
  assert_bus_edge_R5: assert property (@(posedge dst_clk) disable iff (dst_rst)
    (bus_out != $past(bus_out)) |-> $past(b_v[1] && !b_v[2]));

  // R6: update state always hands over to latched with valid high
  assert_bus_upd_R6: assert property (@(posedge src_clk) disable iff (src_rst)
    (b_st == 2'd0) |=> (b_st == 2'd1 && b_vld));

  // R6: clear state never holds valid
  assert_bus_clr_R6: assert property (@(posedge src_clk) disable iff (src_rst)
    (b_st == 2'd2) |-> !b_vld);

  // R7: quasi-static copy lags by one destination clock
  assert_quasi_R7: assert property (@(posedge dst_clk) disable iff (dst_rst)
    !$past(dst_rst) |-> (qs_out == $past(qs_in)));
endmodule

bind cdc_bridge cdc_bridge_chk #(.BUS_W(BUS_W), .QS_W(QS_W)) u_chk (
  .src_clk(src_clk), .src_rst(src_rst), .dst_clk(dst_clk), .dst_rst(dst_rst),
  .pls_out(pls_out), .bus_out(bus_out), .qs_in(qs_in), .qs_out(qs_out),
  .p_req(u_pulse.req), .p_fb(u_pulse.fb),
  .b_st(u_bus.st), .b_vld(u_bus.vld), .b_v(u_bus.v_dst)
);

// File: tb/cdc_bridge_bench.sv
module cdc_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DST_PERIOD = 14;
  localparam int BUS_W = 16;
  localparam int QS_W  = 12;

  logic src_clk = 0, dst_clk = 0;
  logic src_rst = 1, dst_rst = 1;
  logic lvl_in = 0, pls_in = 0;
  logic [BUS_W-1:0] bus_in = '0;
  logic [QS_W-1:0]  qs_in = '0;
  logic lvl_out, pls_out;
  logic [BUS_W-1:0] bus_out;
  logic [QS_W-1:0]  qs_out;

  always #(CLK_PERIOD/2) src_clk = ~src_clk;
  always #(DST_PERIOD/2) dst_clk = ~dst_clk;

  cdc_bridge #(.LVL_STAGES(2), .BUS_W(BUS_W), .QS_W(QS_W)) u_cdc_bridge (
    .src_clk(src_clk), .src_rst(src_rst), .dst_clk(dst_clk), .dst_rst(dst_rst),
    .lvl_in(lvl_in), .lvl_out(lvl_out), .pls_in(pls_in), .pls_out(pls_out),
    .bus_in(bus_in), .bus_out(bus_out), .qs_in(qs_in), .qs_out(qs_out)
  );

  int checks = 0, failures = 0;
  bit mon_on = 0;
  bit done = 0;
  int pls_q[$];
  logic [BUS_W-1:0] bus_q[$];
  logic prev_pls = 0;
  logic [BUS_W-1:0] prev_bus = '0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic src_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge src_clk);
  endtask

  task automatic dst_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge dst_clk);
  endtask

  // driver: one source pulse, with an expected-token push when accepted
  task automatic fire(input bit expect_out, input int id);
    @(negedge src_clk);
    pls_in = 1;
    if (expect_out) pls_q.push_back(id);
    @(negedge src_clk);
    pls_in = 0;
  endtask

  task automatic drive_bus(input logic [BUS_W-1:0] val);
    @(negedge src_clk);
    bus_in = val;
    bus_q.push_back(val);
    src_cycles(40);
  endtask

  // monitor: pops expected items as the design produces results
  always @(negedge dst_clk) begin
    if (mon_on) begin
      if (pls_out) begin
        check(!prev_pls, "R2 pulse width", 2, 1);
        if (!prev_pls) begin
          check(pls_q.size() != 0, "R4 unexpected extra pulse", 1, 0);
          if (pls_q.size() != 0) void'(pls_q.pop_front());
        end
      end
      prev_pls = pls_out;
      if (bus_out != prev_bus) begin
        check(bus_q.size() != 0, "R5 unexpected bus change", bus_out, prev_bus);
        if (bus_q.size() != 0) begin
          logic [BUS_W-1:0] e;
          e = bus_q.pop_front();
          check(bus_out == e, "R5 bus value", bus_out, e);
        end
        prev_bus = bus_out;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bus_in = 16'h1234;
    qs_in = 12'hABC;
    lvl_in = 1;
    src_cycles(6);
    // R8: reset clears every output
    check(lvl_out == 0, "R8 lvl_out in reset", lvl_out, 0);
    check(pls_out == 0, "R8 pls_out in reset", pls_out, 0);
    check(bus_out == 0, "R8 bus_out in reset", bus_out, 0);
    check(qs_out == 0, "R8 qs_out in reset", qs_out, 0);
    lvl_in = 0;
    bus_in = '0;
    @(negedge src_clk); src_rst = 0;
    @(negedge dst_clk); dst_rst = 0;
    dst_cycles(10);
    mon_on = 1;

    // R1: level crossing both ways
    @(negedge src_clk); lvl_in = 1;
    dst_cycles(5);
    check(lvl_out == 1, "R1 level high", lvl_out, 1);
    @(negedge src_clk); lvl_in = 0;
    dst_cycles(5);
    check(lvl_out == 0, "R1 level low", lvl_out, 0);

    // R7: quasi-static values
    @(negedge src_clk); qs_in = 12'hFFF;
    dst_cycles(2);
    check(qs_out == 12'hFFF, "R7 quasi ones", qs_out, 12'hFFF);
    @(negedge src_clk); qs_in = 12'h5A5;
    dst_cycles(2);
    check(qs_out == 12'h5A5, "R7 quasi pattern", qs_out, 12'h5A5);

    // R2/R3: isolated pulses, each accepted after the loop settles
    for (int k = 0; k < 4; k++) begin
      fire(1, k);
      src_cycles(30);
    end
    check(pls_q.size() == 0, "R3 isolated pulses delivered", pls_q.size(), 0);

    // R4: bursts merge into one transfer
    for (int k = 0; k < 3; k++) begin
      fire(1, 10 + k);
      fire(0, 0);
      fire(0, 0);
      src_cycles(30);
    end
    check(pls_q.size() == 0, "R4 merged bursts delivered once", pls_q.size(), 0);

    // R5/R6: continuous bus refresh over several values
    drive_bus(16'hFFFF);
    drive_bus(16'hA5A5);
    drive_bus(16'h0001);
    drive_bus(16'h8000);
    drive_bus(16'h3C3C);
    check(bus_q.size() == 0, "R6 every value refreshed", bus_q.size(), 0);
    check(bus_out == 16'h3C3C, "R5 final bus value", bus_out, 16'h3C3C);

    // R6: a steady bus keeps cycling without disturbing the output
    src_cycles(60);
    check(bus_out == 16'h3C3C, "R6 steady bus unchanged", bus_out, 16'h3C3C);

    dst_cycles(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule